// File: doc/BRIEF.md
# Sub-word Load/Store Lane Unit

This block sits between a core's memory stage and a 32-bit, word-addressed data memory. It takes an access request with an effective byte address, an access size, a signed or unsigned flag and store data. It forwards the request to memory as a word address, a 4-bit byte-enable mask and the store data repeated across every lane. Address arithmetic happens upstream, and the memory is outside the block.

For loads, the block saves each accepted load's size, offset and extension mode in a small in-order tag queue. When the memory word comes back, it uses the oldest tag to pick out the byte or half, sign-extend or zero-extend it, and return it to the core. The `BIG_ENDIAN` parameter sets the byte order inside a word. If a word holding 0x01020304 sits at address 0x1000, a byte load from 0x1000 returns 0x01 in big-endian mode and 0x04 in little-endian mode. The block does not split misaligned accesses. It flags them and drops them.

All three data channels use valid/ready. A transfer happens on a clock edge where both valid and ready are high. The request side waits for the memory's `mem_ready`. A load also waits while the tag queue is full. Stores never wait on the queue. The response path passes back-pressure straight through: a memory word is consumed only when the core takes the extracted result. A legal request reaches `mem_valid` without depending on `mem_ready`.

Top module: `lsl_lane_unit`

## Requirements
- R1: `req_size` encodes 0 = byte, 1 = half, 2 = word. Code 3 is illegal and is handled like a misaligned access.
- R2: A half access needs `req_addr[0]` = 0. A word access needs `req_addr[1:0]` = 0. A request that breaks this, or uses size code 3, raises `misalign` while `req_valid` is high. It holds `mem_valid` low, sees `req_ready` high, and never reaches memory.
- R3: `mem_waddr` equals `req_addr[AW-1:2]`, and `mem_write` follows `req_write`.
- R4: For legal stores, byte offset o enables bit o in little-endian mode and bit 3-o in big-endian mode. A half store at offset 0 enables 4'b0011 in little-endian mode and 4'b1100 in big-endian mode; at offset 2 the masks are swapped. A word store enables 4'b1111. Loads and illegal requests drive 4'b0000.
- R5: Store data is copied into every lane: the low byte four times for a byte store, the low half twice for a half store, the full word for a word store.
- R6: A load at byte offset o reads bits [8o+7:8o] in little-endian mode and bits [31-8o:24-8o] in big-endian mode. A half load at offset 0 reads bits [15:0] in little-endian mode and bits [31:16] in big-endian mode; offset 2 reads the other half.
- R7: A signed load (`req_unsigned` = 0) fills the upper bits with copies of the loaded value's top bit. An unsigned load fills them with zeros. A word load returns all 32 bits unchanged, whatever the flag says.
- R8: `mem_valid` = `req_valid` and legal and (store, or tag queue not full). `req_ready` is high for illegal requests, and otherwise equals `mem_ready` under the same queue condition.
- R9: Load results come back in request order. `ld_valid` is high only while `rsp_mem_valid` is high and a load is outstanding. `rsp_mem_ready` equals `ld_ready` while a load is outstanding and is low otherwise.
- R10: At most `DEPTH` loads are outstanding. While the queue is full, load requests stall and stores still pass.
- R11: After reset no load is outstanding, so `ld_valid` and `rsp_mem_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Zero-extend load result |
| req_addr | input | AW | Effective byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | Memory write |
| mem_waddr | output | AW-2 | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| rsp_mem_valid | input | 1 | Memory read word valid |
| rsp_mem_ready | output | 1 | Memory read word taken |
| rsp_mem_rdata | input | 32 | Memory read word |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Core takes load result |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Illegal or misaligned request flag |

## Verification
The bench runs two copies of the unit, one per byte order, on shared random traffic. An executable model checks every output on every cycle. The traffic includes all four offsets, the illegal size code, and the 0x01020304 example at 0x1000. A swapped lane map would put bytes in mirrored positions. A missing sign copy would leave negative bytes positive.

A stretch with the core withholding `ld_ready` fills the tag queue. That catches a unit that overruns its tags or blocks stores behind loads. Memory words also arrive with no load outstanding, which catches a design that returns or drops unmatched responses.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef struct packed {
    size_e      size;
    logic       zext;
    logic [1:0] off;
  } ld_tag_t;
endpackage

// File: rtl/lsl_store_lanes.sv
module lsl_store_lanes
  import lsl_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  size_e       size,
  input  logic [1:0]  off,
  input  logic [31:0] din,
  output logic [3:0]  be,
  output logic [31:0] dout
);
  logic [1:0] lane;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign lane = 2'd3 - off;
    end else begin : g_le
      assign lane = off;
    end
  endgenerate

  always_comb begin
    case (size)
      SZ_BYTE: begin
        be   = 4'b0001 << lane;
        dout = {4{din[7:0]}};
      end
      SZ_HALF: begin
        be   = (off[1] ^ BIG_ENDIAN) ? 4'b1100 : 4'b0011;
        dout = {2{din[15:0]}};
      end
      default: begin
        be   = 4'b1111;
        dout = din;
      end
    endcase
  end
endmodule

// File: rtl/lsl_load_extract.sv
module lsl_load_extract
  import lsl_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  ld_tag_t     tag,
  input  logic [31:0] word,
  output logic [31:0] dout
);
  logic [1:0]  lane;
  logic        upper_half;
  logic [7:0]  b;
  logic [15:0] h;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign lane       = 2'd3 - tag.off;
      assign upper_half = ~tag.off[1];
    end else begin : g_le
      assign lane       = tag.off;
      assign upper_half = tag.off[1];
    end
  endgenerate

  always_comb begin
    b = word[8*lane +: 8];
    h = upper_half ? word[31:16] : word[15:0];
    case (tag.size)
      SZ_BYTE: dout = {{24{b[7] & ~tag.zext}}, b};
      SZ_HALF: dout = {{16{h[15] & ~tag.zext}}, h};
      default: dout = word;
    endcase
  end
endmodule

// File: rtl/lsl_tag_fifo.sv
module lsl_tag_fifo
  import lsl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  ld_tag_t din,
  input  logic    pop,
  output ld_tag_t dout,
  output logic    full,
  output logic    empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ld_tag_t        slots [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = slots[rp];

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10
  tag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full);
endmodule

// File: rtl/lsl_lane_unit.sv
module lsl_lane_unit
  import lsl_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DEPTH      = 4,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-3:0] mem_waddr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          rsp_mem_valid,
  output logic          rsp_mem_ready,
  input  logic [31:0]   rsp_mem_rdata,
  output logic          ld_valid,
  input  logic          ld_ready,
  output logic [31:0]   ld_data,
  output logic          misalign
);
  size_e      size;
  logic       legal, can_go, push, pop, full, empty;
  logic [3:0] st_be;
  ld_tag_t    new_tag, head_tag;

  assign size = size_e'(req_size);

  always_comb begin
    case (size)
      SZ_BYTE: legal = 1'b1;
      SZ_HALF: legal = ~req_addr[0];
      SZ_WORD: legal = (req_addr[1:0] == 2'b00);
      default: legal = 1'b0;
    endcase
  end

  assign can_go    = req_write | ~full;
  assign mem_valid = req_valid & legal & can_go;
  assign req_ready = ~legal | (mem_ready & can_go);
  assign misalign  = req_valid & ~legal;
  assign mem_write = req_write;
  assign mem_waddr = req_addr[AW-1:2];
  assign mem_be    = (req_write & legal) ? st_be : 4'b0000;

  lsl_store_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_st (
    .size (size),
    .off  (req_addr[1:0]),
    .din  (req_wdata),
    .be   (st_be),
    .dout (mem_wdata)
  );

  assign new_tag = '{size: size, zext: req_unsigned, off: req_addr[1:0]};
  assign push    = req_valid & legal & ~req_write & mem_ready & ~full;
  assign pop     = ld_valid & ld_ready;

  lsl_tag_fifo #(.DEPTH(DEPTH)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (new_tag),
    .pop   (pop),
    .dout  (head_tag),
    .full  (full),
    .empty (empty)
  );

  assign ld_valid      = rsp_mem_valid & ~empty;
  assign rsp_mem_ready = ld_ready & ~empty;

  lsl_load_extract #(.BIG_ENDIAN(BIG_ENDIAN)) u_ld (
    .tag  (head_tag),
    .word (rsp_mem_rdata),
    .dout (ld_data)
  );

  // R2
  misalign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_valid && req_ready);

  // R4
  load_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |-> mem_be == 4'b0000);

  // R4
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && req_size == 2'd0 |-> $countones(mem_be) == 1);

  // R7
  zext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && head_tag.zext && head_tag.size == SZ_BYTE |-> ld_data[31:8] == 24'd0);

  // R9
  rsp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_mem_ready |-> !empty);
endmodule

// File: tb/lsl_lane_unit_tb.sv
module lsl_lane_unit_tb;
  localparam int AW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_unsigned = 0;
  logic [1:0]    req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0]   req_wdata = 0;
  logic          mem_ready = 0, rsp_mem_valid = 0, ld_ready = 0;
  logic [31:0]   rsp_mem_rdata = 0;

  logic          b_req_ready, b_mem_valid, b_mem_write, b_rsp_ready, b_ld_valid, b_mis;
  logic [AW-3:0] b_waddr;
  logic [3:0]    b_be;
  logic [31:0]   b_wdata, b_ld_data;
  logic          l_req_ready, l_mem_valid, l_mem_write, l_rsp_ready, l_ld_valid, l_mis;
  logic [AW-3:0] l_waddr;
  logic [3:0]    l_be;
  logic [31:0]   l_wdata, l_ld_data;

  lsl_lane_unit #(.AW(AW), .DEPTH(DEPTH), .BIG_ENDIAN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_req_ready),
    .req_write(req_write), .req_size(req_size), .req_unsigned(req_unsigned),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_valid(b_mem_valid),
    .mem_ready(mem_ready), .mem_write(b_mem_write), .mem_waddr(b_waddr),
    .mem_be(b_be), .mem_wdata(b_wdata), .rsp_mem_valid(rsp_mem_valid),
    .rsp_mem_ready(b_rsp_ready), .rsp_mem_rdata(rsp_mem_rdata),
    .ld_valid(b_ld_valid), .ld_ready(ld_ready), .ld_data(b_ld_data), .misalign(b_mis));

  lsl_lane_unit #(.AW(AW), .DEPTH(DEPTH), .BIG_ENDIAN(1'b0)) u_dut_le (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(l_req_ready),
    .req_write(req_write), .req_size(req_size), .req_unsigned(req_unsigned),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_valid(l_mem_valid),
    .mem_ready(mem_ready), .mem_write(l_mem_write), .mem_waddr(l_waddr),
    .mem_be(l_be), .mem_wdata(l_wdata), .rsp_mem_valid(rsp_mem_valid),
    .rsp_mem_ready(l_rsp_ready), .rsp_mem_rdata(rsp_mem_rdata),
    .ld_valid(l_ld_valid), .ld_ready(ld_ready), .ld_data(l_ld_data), .misalign(l_mis));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state: outstanding load descriptors {size, zext, off} and memory words
  logic [4:0]  tagq[$];
  logic [31:0] memq[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_at(logic [AW-3:0] wa);
    if (wa == 14'h0400) return 32'h01020304;
    return {wa, 2'b00, wa[7:0], ~wa[7:0]} ^ 32'h5A5AA5A5 ^ (32'(wa) * 32'h9E3779B1);
  endfunction

  function automatic bit is_legal(logic [1:0] sz, logic [1:0] off);
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return off[0] == 1'b0;
    if (sz == 2'd2) return off == 2'b00;
    return 0;
  endfunction

  function automatic logic [3:0] exp_mask(bit big, logic [1:0] sz, logic [1:0] off);
    int o = int'(off);
    if (sz == 2'd0) return 4'(1 << (big ? 3 - o : o));
    if (sz == 2'd1) return ((o == 0) ^ big) ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_rep(logic [1:0] sz, logic [31:0] d);
    if (sz == 2'd0) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (sz == 2'd1) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] exp_load(bit big, logic [4:0] t, logic [31:0] w);
    logic [1:0] sz = t[4:3];
    bit zx = t[2];
    int o = int'(t[1:0]);
    int sh;
    logic [31:0] v;
    if (sz == 2'd0) begin
      sh = big ? 8 * (3 - o) : 8 * o;
      v = (w >> sh) & 32'hFF;
      if (!zx && v[7]) v = v | 32'hFFFFFF00;
      return v;
    end
    if (sz == 2'd1) begin
      sh = ((o == 0) ^ big) ? 0 : 16;
      v = (w >> sh) & 32'hFFFF;
      if (!zx && v[15]) v = v | 32'hFFFF0000;
      return v;
    end
    return w;
  endfunction

  task automatic cmp_one(bit big, logic rr, logic mv, logic mw, logic [AW-3:0] wa,
                         logic [3:0] be, logic [31:0] wd, logic rsr, logic lv,
                         logic [31:0] ld, logic mis);
    bit lg = is_legal(req_size, req_addr[1:0]);
    bit roomy = req_write || (tagq.size() < DEPTH);
    bit outst = tagq.size() > 0;
    string e = big ? "big" : "little";
    chk("R2", {e, " misalign"}, 32'(mis), 32'(req_valid && !lg));
    chk("R8", {e, " mem_valid"}, 32'(mv), 32'(req_valid && lg && roomy));
    chk("R8", {e, " req_ready"}, 32'(rr), 32'(!lg || (mem_ready && roomy)));
    chk("R3", {e, " mem_write"}, 32'(mw), 32'(req_write));
    chk("R3", {e, " mem_waddr"}, 32'(wa), 32'(req_addr[AW-1:2]));
    chk("R4", {e, " mem_be"}, 32'(be),
        32'((req_write && lg) ? exp_mask(big, req_size, req_addr[1:0]) : 4'b0000));
    if (req_size != 2'd3) chk("R5", {e, " mem_wdata"}, wd, exp_rep(req_size, req_wdata));
    chk("R9", {e, " ld_valid"}, 32'(lv), 32'(rsp_mem_valid && outst));
    chk("R9", {e, " rsp_mem_ready"}, 32'(rsr), 32'(ld_ready && outst));
    if (rsp_mem_valid && outst)
      chk("R6 R7", {e, " ld_data"}, ld, exp_load(big, tagq[0], rsp_mem_rdata));
  endtask

  task automatic cycle(bit rv, bit wr, logic [1:0] sz, bit uz, logic [AW-1:0] a,
                       logic [31:0] wd, bit mr, bit lr, bit rsv);
    bit lg, roomy, outst;
    @(negedge clk);
    req_valid = rv; req_write = wr; req_size = sz; req_unsigned = uz;
    req_addr = a; req_wdata = wd; mem_ready = mr; ld_ready = lr;
    rsp_mem_valid = rsv && (memq.size() > 0 || ($urandom % 2 == 0));
    rsp_mem_rdata = (memq.size() > 0) ? memq[0] : $urandom;
    #1;
    cmp_one(1'b1, b_req_ready, b_mem_valid, b_mem_write, b_waddr, b_be, b_wdata,
            b_rsp_ready, b_ld_valid, b_ld_data, b_mis);
    cmp_one(1'b0, l_req_ready, l_mem_valid, l_mem_write, l_waddr, l_be, l_wdata,
            l_rsp_ready, l_ld_valid, l_ld_data, l_mis);
    lg = is_legal(sz, a[1:0]);
    roomy = tagq.size() < DEPTH;
    outst = tagq.size() > 0;
    if (rsp_mem_valid && outst && lr) begin
      void'(tagq.pop_front());
      void'(memq.pop_front());
    end
    if (rv && lg && !wr && mr && roomy) begin
      tagq.push_back({sz, uz, a[1:0]});
      memq.push_back(word_at(a[AW-1:2]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: no load outstanding out of reset
    chk("R11", "ld_valid in reset", 32'(b_ld_valid | l_ld_valid), 32'd0);
    rsp_mem_valid = 1'b1; ld_ready = 1'b1;
    #1;
    chk("R11", "rsp_mem_ready in reset", 32'(b_rsp_ready | l_rsp_ready), 32'd0);
    rsp_mem_valid = 1'b0; ld_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R11", "ld_valid after reset", 32'(b_ld_valid | l_ld_valid), 32'd0);
    // R6 endianness example: byte loads at each offset of word 0x1000
    for (int i = 0; i < 4; i++)
      cycle(1, 0, 2'd0, 0, 16'h1000 + 16'(i), 0, 1, 1, 1);
    for (int i = 0; i < 8; i++) cycle(0, 0, 2'd0, 0, 0, 0, 1, 1, 1);
    // R10: fill the tag queue with the core stalled, stores still flow
    for (int i = 0; i < 40; i++)
      cycle(1, (i % 3 == 0), 2'(i % 3), i[0], 16'h1000 + 16'(i * 2), $urandom, 1, 0, 1);
    // mixed random traffic including misaligned and illegal codes (R1, R2)
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      logic [AW-1:0] a = ($urandom % 4 == 0) ? 16'h1000 + 16'($urandom % 4) : 16'($urandom);
      bit stall = (i > 1500 && i < 1700);
      cycle($urandom % 4 != 0, $urandom % 2, sz, $urandom % 2, a, $urandom,
            $urandom % 4 != 0, !stall && ($urandom % 3 != 0), $urandom % 3 != 0);
    end
    // drain
    for (int i = 0; i < 20; i++) cycle(0, 0, 2'd0, 0, 0, 0, 1, 1, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule